// File: doc/BRIEF.md
# Display Command Sequencer with Timed Waits

This block drives a character display module over an 8-bit parallel bus from the host side. Requests arrive on a valid/ready handshake. Each request carries a byte and one select bit that picks the data register (1) or the instruction register (0). For each accepted request the block places the select bit, a write direction and the byte on the bus. It then raises the enable strobe for a fixed number of cycles, with set-up before the rising edge and hold after the falling edge.

After the strobe the block stays busy, with ready low, until the display can take the next transfer. In timed mode it counts a wait whose length it finds by decoding the request:
- a long wait for the clear and return-home instructions;
- a short wait for every other instruction;
- a slightly longer wait for data writes.

In poll mode it instead issues read strobes that select the instruction register. During these reads it releases the data bus and inspects bit 7 of the returned byte, which is the busy flag. Once the flag reads low it waits a short guard gap before it takes the next request. All durations are parameters in clock cycles. By default they are derived from the clock frequency and rounded up.

Top module: `chardisp_sequencer`

## Requirements
- R1: During and after synchronous reset, `req_ready` is 1, `bus_strobe` is 0, `bus_read` is 0 and `bus_drive` is 1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the request's wait has ended, and request inputs that change while `req_ready` is 0 have no effect on the bus.
- R3: For a write, `bus_sel_data`, `bus_read`=0 and `bus_dout` (equal to the request byte and select bit) stand for SETUP_CYC cycles before `bus_strobe` rises. `bus_strobe` stays 1 for PULSE_CYC cycles, and the values hold for HOLD_CYC cycles after it falls.
- R4: In timed mode, an instruction (select bit 0) with byte 0x01, 0x02 or 0x03 keeps `req_ready` low for SETUP_CYC+PULSE_CYC+HOLD_CYC+LONG_CYC cycles after acceptance.
- R5: In timed mode, an instruction with any other byte keeps `req_ready` low for SETUP_CYC+PULSE_CYC+HOLD_CYC+SHORT_CYC cycles.
- R6: In timed mode, a data write (select bit 1) keeps `req_ready` low for SETUP_CYC+PULSE_CYC+HOLD_CYC+DATA_CYC cycles, whatever the byte.
- R7: In poll mode, after the write the block issues read strobes with `bus_read`=1 and `bus_sel_data`=0, using the same set-up, pulse and hold lengths. It samples `bus_din[7]` (1 = busy) in the last strobe cycle and repeats the read while the sample is 1. The other bits of `bus_din` are ignored.
- R8: In poll mode, after the first read that samples the flag as 0, `req_ready` returns to 1 after a further GAP_CYC cycles. The total busy time for K busy reads is (K+2)·(SETUP_CYC+PULSE_CYC+HOLD_CYC)+GAP_CYC.
- R9: `bus_drive` is 0 exactly while `bus_read` is 1, and 1 otherwise, including in idle.
- R10: `poll_mode` is sampled at acceptance; changing it during a request does not change how that request finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_is_data | input | 1 | 1 = data register, 0 = instruction register |
| req_byte | input | 8 | Instruction code or data byte |
| poll_mode | input | 1 | 1 = poll busy flag, 0 = timed wait |
| bus_sel_data | output | 1 | Register select towards the display |
| bus_read | output | 1 | 1 = read cycle, 0 = write cycle |
| bus_strobe | output | 1 | Enable strobe |
| bus_dout | output | 8 | Byte driven onto the bus |
| bus_drive | output | 1 | Output enable for the bus byte (0 = released) |
| bus_din | input | 8 | Byte returned by the display during reads |

## Verification
A wrong decode, or a phase counter loaded with the wrong length, shows up as a busy window on `req_ready` of the wrong length. The error is visible on the first request of the affected class, within that one transaction. A stale captured request or a late latch of the mode shows up during the very next strobe, either as a wrong byte or select bit while `bus_strobe` is high, or as read strobes that are missing or extra. A wrong busy-flag sample changes the number of read strobes, so the error appears within one poll round.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;

    typedef enum logic [1:0] {
        WC_LONG  = 2'd0,
        WC_SHORT = 2'd1,
        WC_DATA  = 2'd2
    } wait_cls_t;

    typedef enum logic [3:0] {
        ST_IDLE    = 4'd0,
        ST_WSETUP  = 4'd1,
        ST_WSTROBE = 4'd2,
        ST_WHOLD   = 4'd3,
        ST_WAIT    = 4'd4,
        ST_PSETUP  = 4'd5,
        ST_PSTROBE = 4'd6,
        ST_PHOLD   = 4'd7,
        ST_GAP     = 4'd8
    } seq_state_t;

    typedef struct packed {
        logic       is_data;
        logic [7:0] code;
        wait_cls_t  cls;
        logic       poll;
    } req_t;

    typedef struct packed {
        logic       sel_data;
        logic       read;
        logic       strobe;
        logic       drive;
        logic [7:0] dout;
    } pins_t;

    function automatic wait_cls_t classify(input logic is_data, input logic [7:0] b);
        if (is_data)
            return WC_DATA;
        else if (b == 8'h01 || b[7:1] == 7'b0000001)
            return WC_LONG;
        else
            return WC_SHORT;
    endfunction

    function automatic int unsigned ns_to_cyc(input longint unsigned ns,
                                              input longint unsigned hz);
        return int'((ns * hz + 64'd999_999_999) / 64'd1_000_000_000);
    endfunction

    function automatic int unsigned at_least_one(input int unsigned v);
        return (v < 1) ? 1 : v;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/chardisp_req_latch.sv
module chardisp_req_latch
    import chardisp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    input  logic       in_is_data,
    input  logic [7:0] in_byte,
    input  logic       in_poll,
    output req_t       cur
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '{is_data: 1'b0, code: 8'h00, cls: WC_SHORT, poll: 1'b0};
        end else if (take) begin
            cur.is_data <= in_is_data;
            cur.code    <= in_byte;
            cur.cls     <= classify(in_is_data, in_byte);
            cur.poll    <= in_poll;
        end
    end
endmodule

// File: rtl/chardisp_phase_timer.sv
module chardisp_phase_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/chardisp_seq_fsm.sv
module chardisp_seq_fsm
    import chardisp_pkg::*;
#(
    parameter int unsigned CW        = 8,
    parameter int unsigned SETUP_CYC = 1,
    parameter int unsigned PULSE_CYC = 1,
    parameter int unsigned HOLD_CYC  = 1,
    parameter int unsigned LONG_CYC  = 1,
    parameter int unsigned SHORT_CYC = 1,
    parameter int unsigned DATA_CYC  = 1,
    parameter int unsigned GAP_CYC   = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  req_t          cur,
    input  logic          expired,
    input  logic          busy_bit,
    output logic          ready,
    output logic          take,
    output logic          load,
    output logic [CW-1:0] load_val,
    output pins_t         pins
);
    localparam logic [CW-1:0] SETUP_V = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] PULSE_V = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] HOLD_V  = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] LONG_V  = CW'(LONG_CYC - 1);
    localparam logic [CW-1:0] SHORT_V = CW'(SHORT_CYC - 1);
    localparam logic [CW-1:0] DATA_V  = CW'(DATA_CYC - 1);
    localparam logic [CW-1:0] GAP_V   = CW'(GAP_CYC - 1);

    seq_state_t    state, nxt;
    logic          busy_q;
    logic [CW-1:0] wait_v;

    assign ready = (state == ST_IDLE);
    assign take  = ready && req_valid;

    always_comb begin
        unique case (cur.cls)
            WC_LONG:  wait_v = LONG_V;
            WC_DATA:  wait_v = DATA_V;
            default:  wait_v = SHORT_V;
        endcase
    end

    always_comb begin
        nxt      = state;
        load     = 1'b0;
        load_val = '0;
        unique case (state)
            ST_IDLE: if (take) begin
                nxt = ST_WSETUP; load = 1'b1; load_val = SETUP_V;
            end
            ST_WSETUP: if (expired) begin
                nxt = ST_WSTROBE; load = 1'b1; load_val = PULSE_V;
            end
            ST_WSTROBE: if (expired) begin
                nxt = ST_WHOLD; load = 1'b1; load_val = HOLD_V;
            end
            ST_WHOLD: if (expired) begin
                load = 1'b1;
                if (cur.poll) begin
                    nxt = ST_PSETUP; load_val = SETUP_V;
                end else begin
                    nxt = ST_WAIT; load_val = wait_v;
                end
            end
            ST_WAIT: if (expired) nxt = ST_IDLE;
            ST_PSETUP: if (expired) begin
                nxt = ST_PSTROBE; load = 1'b1; load_val = PULSE_V;
            end
            ST_PSTROBE: if (expired) begin
                nxt = ST_PHOLD; load = 1'b1; load_val = HOLD_V;
            end
            ST_PHOLD: if (expired) begin
                load = 1'b1;
                if (busy_q) begin
                    nxt = ST_PSETUP; load_val = SETUP_V;
                end else begin
                    nxt = ST_GAP; load_val = GAP_V;
                end
            end
            ST_GAP: if (expired) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            busy_q <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_PSTROBE && expired)
                busy_q <= busy_bit;
        end
    end

    // Bus pin decode: read phases release the bus and select the instruction register.
    always_comb begin
        pins.dout   = cur.code;
        pins.strobe = (state == ST_WSTROBE) || (state == ST_PSTROBE);
        unique case (state)
            ST_PSETUP, ST_PSTROBE, ST_PHOLD, ST_GAP: begin
                pins.sel_data = 1'b0;
                pins.read     = 1'b1;
                pins.drive    = 1'b0;
            end
            default: begin
                pins.sel_data = cur.is_data;
                pins.read     = 1'b0;
                pins.drive    = 1'b1;
            end
        endcase
    end

    AST_STROBE_STEADY: assert property (@(posedge clk) disable iff (rst)
        pins.strobe |-> ($stable(pins.sel_data) && $stable(pins.read) && $stable(pins.dout))); // R3
    AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst)
        $fell(pins.strobe) |-> ($stable(pins.sel_data) && $stable(pins.read) && $stable(pins.dout))); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        ready |-> (!pins.strobe && !pins.read)); // R2
    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
        pins.read |-> (!pins.sel_data && !pins.drive)); // R7
    AST_DRIVE_WRITE: assert property (@(posedge clk) disable iff (rst)
        !pins.read |-> pins.drive); // R9
    AST_NO_STROBE_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT || state == ST_GAP) |-> !pins.strobe); // R4
endmodule

// File: rtl/chardisp_sequencer.sv
module chardisp_sequencer
    import chardisp_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 50_000_000,
    parameter int unsigned SETUP_CYC  = ns_to_cyc(40, CLK_HZ),
    parameter int unsigned PULSE_CYC  = ns_to_cyc(230, CLK_HZ),
    parameter int unsigned HOLD_CYC   = ns_to_cyc(10, CLK_HZ),
    parameter int unsigned LONG_CYC   = ns_to_cyc(1_530_000, CLK_HZ),
    parameter int unsigned SHORT_CYC  = ns_to_cyc(39_000, CLK_HZ),
    parameter int unsigned DATA_CYC   = ns_to_cyc(43_000, CLK_HZ),
    parameter int unsigned GAP_CYC    = ns_to_cyc(1_852, CLK_HZ)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic       req_is_data,
    input  logic [7:0] req_byte,
    input  logic       poll_mode,
    output logic       bus_sel_data,
    output logic       bus_read,
    output logic       bus_strobe,
    output logic [7:0] bus_dout,
    output logic       bus_drive,
    input  logic [7:0] bus_din
);
    localparam int unsigned S_L = at_least_one(SETUP_CYC);
    localparam int unsigned P_L = at_least_one(PULSE_CYC);
    localparam int unsigned H_L = at_least_one(HOLD_CYC);
    localparam int unsigned L_L = at_least_one(LONG_CYC);
    localparam int unsigned T_L = at_least_one(SHORT_CYC);
    localparam int unsigned D_L = at_least_one(DATA_CYC);
    localparam int unsigned G_L = at_least_one(GAP_CYC);
    localparam int unsigned MAXC =
        max2(max2(max2(S_L, P_L), max2(H_L, L_L)), max2(max2(T_L, D_L), G_L));
    localparam int unsigned CW = $clog2(MAXC + 1);

    req_t          cur;
    pins_t         pins;
    logic          take, load, expired;
    logic [CW-1:0] load_val;

    chardisp_req_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .in_is_data (req_is_data),
        .in_byte    (req_byte),
        .in_poll    (poll_mode),
        .cur        (cur)
    );

    chardisp_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    chardisp_seq_fsm #(
        .CW(CW), .SETUP_CYC(S_L), .PULSE_CYC(P_L), .HOLD_CYC(H_L),
        .LONG_CYC(L_L), .SHORT_CYC(T_L), .DATA_CYC(D_L), .GAP_CYC(G_L)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .cur       (cur),
        .expired   (expired),
        .busy_bit  (bus_din[7]),
        .ready     (req_ready),
        .take      (take),
        .load      (load),
        .load_val  (load_val),
        .pins      (pins)
    );

    assign bus_sel_data = pins.sel_data;
    assign bus_read     = pins.read;
    assign bus_strobe   = pins.strobe;
    assign bus_dout     = pins.dout;
    assign bus_drive    = pins.drive;

    AST_READY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R2
endmodule

// File: tb/tb_chardisp_sequencer.sv
module tb_chardisp_sequencer;
    localparam int S = 2, P = 3, H = 1;
    localparam int LW = 40, SW = 9, DW = 12, G = 5;
    localparam int SPH = S + P + H;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0, req_is_data = 1'b0, poll_mode = 1'b0;
    logic [7:0] req_byte = 8'h00;
    logic       req_ready, bus_sel_data, bus_read, bus_strobe, bus_drive;
    logic [7:0] bus_dout, bus_din;
    int         busy_left = 0;
    int         errors = 0, checks = 0;
    bit         done = 1'b0;

    assign bus_din = {(busy_left > 0), 7'h7F};

    always #10 clk = ~clk;

    chardisp_sequencer #(
        .SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H),
        .LONG_CYC(LW), .SHORT_CYC(SW), .DATA_CYC(DW), .GAP_CYC(G)
    ) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_is_data(req_is_data), .req_byte(req_byte), .poll_mode(poll_mode),
        .bus_sel_data(bus_sel_data), .bus_read(bus_read), .bus_strobe(bus_strobe),
        .bus_dout(bus_dout), .bus_drive(bus_drive), .bus_din(bus_din)
    );

    task automatic chk(input string tag, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input bit d, input logic [7:0] b, input bit poll,
                        input int k, input int wcyc, input string tag);
        int low, en_cnt, first_en, bad_w, bad_p, polls, exp_low;
        bit prev_en;
        @(negedge clk);
        chk("R2 ready before request", req_ready === 1'b1, int'(req_ready), 1);
        req_valid = 1'b1; req_is_data = d; req_byte = b; poll_mode = poll; busy_left = k;
        @(negedge clk);
        // keep valid high with other values: must not be taken while busy (R2, R10)
        req_is_data = ~d; req_byte = ~b; poll_mode = ~poll;
        low = 0; en_cnt = 0; first_en = -1; bad_w = 0; bad_p = 0; polls = 0; prev_en = 1'b0;
        while (req_ready === 1'b0 && low < 5000) begin
            if (bus_strobe) begin
                en_cnt++;
                if (first_en < 0) first_en = low;
                if (bus_read) begin
                    if (bus_sel_data !== 1'b0 || bus_drive !== 1'b0) bad_p++;
                end else if (bus_sel_data !== d || bus_dout !== b || bus_drive !== 1'b1) begin
                    bad_w++;
                end
            end
            if (prev_en && !bus_strobe && bus_read) begin
                polls++;
                if (busy_left > 0) busy_left--;
            end
            prev_en = bus_strobe;
            low++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        exp_low = poll ? (k + 2) * SPH + G : SPH + wcyc;
        chk(tag, low == exp_low, low, exp_low);
        chk("R3 strobe set-up", first_en == S, first_en, S);
        chk("R3 strobe width", en_cnt == P * (poll ? k + 2 : 1), en_cnt, P * (poll ? k + 2 : 1));
        chk("R3 R2 write values during strobe", bad_w == 0, bad_w, 0);
        chk("R10 mode latched at accept", polls == (poll ? k + 1 : 0), polls, poll ? k + 1 : 0);
        chk("R9 drive in idle", bus_drive === 1'b1 && bus_strobe === 1'b0, int'(bus_drive), 1);
        if (poll) chk("R7 R9 read values", bad_p == 0, bad_p, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", req_ready === 1'b1, int'(req_ready), 1);
        chk("R1 strobe in reset", bus_strobe === 1'b0, int'(bus_strobe), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready after reset", req_ready === 1'b1, int'(req_ready), 1);
        chk("R1 read after reset", bus_read === 1'b0, int'(bus_read), 0);
        chk("R1 drive after reset", bus_drive === 1'b1, int'(bus_drive), 1);
        // exhaustive timed sweep: byte 0x01..0x03 with select 0 is long (R4),
        // other instructions short (R5), every data byte uses the data wait (R6)
        for (int d = 0; d < 2; d++) begin
            for (int b = 0; b < 256; b++) begin
                if (d == 1)
                    send(1'b1, 8'(b), 1'b0, 0, DW, "R6 data wait");
                else if (b >= 1 && b <= 3)
                    send(1'b0, 8'(b), 1'b0, 0, LW, "R4 long wait");
                else
                    send(1'b0, 8'(b), 1'b0, 0, SW, "R5 short wait");
            end
        end
        // poll mode: K busy reads then the guard gap (R7, R8)
        for (int k = 0; k < 4; k++) begin
            send(1'b0, 8'h01, 1'b1, k, 0, "R8 poll busy time");
            send(1'b1, 8'hA5, 1'b1, k, 0, "R8 poll busy time");
            send(1'b0, 8'h38, 1'b1, k, 0, "R7 poll busy time");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule